// File: doc/BRIEF.md
# Message Buffer Command Controller

This block holds the byte-addressed register file through which software moves whole messages onto and off a single-wire consumer-electronics control bus. Software fills a 16-byte transmit buffer, sets a length, and issues a two-bit command. A small state machine then hands the message to a bit-level line engine through a start/abort/done/error handshake. In the other direction, bytes that the line engine delivers are kept in a 16-byte receive buffer, but only when the header addresses this node. Each side reports a four-state status and raises its own interrupt request.

Register accesses are single-cycle: a write takes effect at the clock edge where `regWe` is high, and `regRdata` combinationally returns the register selected by `regAddr`. The line engine reads transmit bytes by index through `txRdIdx`/`txRdByte`. It delivers received bytes one per cycle, with flags that mark the header byte and the final byte.

Top module: `msg_buf_ctrl`

## Requirements
- R1: After reset, both status registers (transmit 0x93, receive 0x91) read 0, the received-message count (0x92) reads 0, and `txIrq`, `rxIrq`, `txStart` and `txAbort` are low.
- R2: Transmit bytes are written and read at 0x00–0x0F, and the transmit length (message bytes minus one, 0 = header only) at 0x10. The line engine sees that length on `txLen` and the byte at index `txRdIdx` on `txRdByte`.
- R3: Writing transmit command 1 (send current) or 3 (send next) to 0x11 while the transmit status is not 1 sets the status to 1 (busy) and pulses `txStart` high for exactly the one cycle after the write.
- R4: While busy, a `txDone` pulse sets the transmit status to 2 (success) when `txErr` is low and to 3 (error) when it is high, and it raises `txIrq`.
- R5: Transmit command 2 (abort) while busy returns the status to 0, pulses `txAbort` for one cycle and leaves `txIrq` low.
- R6: Transmit command 0 written after completion returns the status to 0. Any write to the transmit command register drops `txIrq`.
- R7: Writing 1 to the transmit clear register (0x13) empties the transmit bytes and length to zero until 0 is written there.
- R8: The logical-address register at 0x16 holds the address in bits [3:0] and an enable in bit 4. A frame is stored only while the enable is set and the header's low nibble equals that address or 0xF. Other frames leave status, count and buffer unchanged.
- R9: A stored frame is readable at 0x80 onward, with its length minus one at 0x90. On its final byte the receive status becomes 2, the count becomes 1 and `rxIrq` rises.
- R10: A frame that ends with `rxErr`, or that carries more than 16 bytes, ends with receive status 3. Bytes beyond the sixteenth are dropped and the length reads 15.
- R11: While the count is 1, new frames are ignored. Receive command 1 or 3 at 0x14 sets the count and status to 0 and drops `rxIrq`.
- R12: Receive command 2 blocks reception until receive command 0, 1 or 3 is written.
- R13: Writing 1 to the receive clear register (0x15) zeroes the receive buffer, count and status and drops `rxIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| txStart | output | 1 | One-cycle request to the line engine to send |
| txAbort | output | 1 | One-cycle request to the line engine to stop |
| txLen | output | 4 | Transmit length, bytes minus one |
| txRdIdx | input | 4 | Line engine transmit byte index |
| txRdByte | output | 8 | Transmit byte at `txRdIdx` |
| txDone | input | 1 | Line engine finished sending |
| txErr | input | 1 | Qualifies `txDone` as failed |
| rxValid | input | 1 | Received byte valid |
| rxByte | input | 8 | Received byte |
| rxFirst | input | 1 | Byte is the header |
| rxEnd | input | 1 | Byte is the last of its frame |
| rxErr | input | 1 | Frame ended with a line error |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The assertions check on every cycle that a send request and an abort leave the transmit status in the matching state. They also check that each interrupt request only stands alongside a completed status or a stored message, that reception only starts while the address enable is set and the buffer is empty, and that a receive clear leaves the receive side idle. Only the directed scenarios can show the data path. That covers which bytes land at which address, the length arithmetic, header filtering against address and broadcast, overflow truncation and the lock-out while a message waits.

// File: rtl/msg_buf_pkg.sv
package msg_buf_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int BUF_BYTES = 16;
  localparam int IDX_W     = $clog2(BUF_BYTES);
  localparam int FILL_W    = IDX_W + 1;
  localparam int LA_W      = 4;

  localparam logic [ADDR_W-1:0] A_TX_LEN   = 8'h10;
  localparam logic [ADDR_W-1:0] A_TX_CMD   = 8'h11;
  localparam logic [ADDR_W-1:0] A_TX_CLR   = 8'h13;
  localparam logic [ADDR_W-1:0] A_RX_CMD   = 8'h14;
  localparam logic [ADDR_W-1:0] A_RX_CLR   = 8'h15;
  localparam logic [ADDR_W-1:0] A_LADDR    = 8'h16;
  localparam logic [ADDR_W-1:0] A_RX_LEN   = 8'h90;
  localparam logic [ADDR_W-1:0] A_RX_STAT  = 8'h91;
  localparam logic [ADDR_W-1:0] A_RX_CNT   = 8'h92;
  localparam logic [ADDR_W-1:0] A_TX_STAT  = 8'h93;
  localparam logic [3:0]        PAGE_TX    = 4'h0;
  localparam logic [3:0]        PAGE_RX    = 4'h8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_OK = 2'd2, ST_ERR = 2'd3
  } stat_e;

  localparam logic [1:0] CMD_NOP  = 2'd0;
  localparam logic [1:0] CMD_CUR  = 2'd1;
  localparam logic [1:0] CMD_STOP = 2'd2;
  localparam logic [1:0] CMD_NEXT = 2'd3;

  // control -> datapath
  typedef struct packed {
    logic rxWrFirst;
    logic rxWrMore;
  } dp_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic            txCmdWr;
    logic [1:0]      txCmdVal;
    logic            rxCmdWr;
    logic [1:0]      rxCmdVal;
    logic            rxClr;
    logic            laEn;
    logic [LA_W-1:0] laVal;
    logic            rxFull;
  } dp_state_t;
endpackage

// File: rtl/msg_buf_dp.sv
module msg_buf_dp
  import msg_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] rxByte,
  input  dp_strobe_t        strobe,
  input  logic [IDX_W-1:0]  txRdIdx,
  output logic [DATA_W-1:0] txRdByte,
  output logic [IDX_W-1:0]  txLen,
  input  stat_e             txStat,
  input  stat_e             rxStat,
  input  logic              rxCnt,
  output dp_state_t         st
);
  logic [DATA_W-1:0] txBuf [BUF_BYTES];
  logic [DATA_W-1:0] rxBuf [BUF_BYTES];
  logic [IDX_W-1:0]  txLenR;
  logic [1:0]        txCmdR, rxCmdR;
  logic              txClrR, rxClrR;
  logic [LA_W:0]     laR;
  logic [FILL_W-1:0] rxFill;
  logic [DATA_W-1:0] rxLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) begin
        txBuf[i] <= '0;
        rxBuf[i] <= '0;
      end
      txLenR <= '0; txCmdR <= '0; rxCmdR <= '0;
      txClrR <= 1'b0; rxClrR <= 1'b0; laR <= '0; rxFill <= '0;
    end else begin
      if (regWe) begin
        if (regAddr[7:4] == PAGE_TX) txBuf[regAddr[IDX_W-1:0]] <= regWdata;
        case (regAddr)
          A_TX_LEN: txLenR <= regWdata[IDX_W-1:0];
          A_TX_CMD: txCmdR <= regWdata[1:0];
          A_TX_CLR: txClrR <= regWdata[0];
          A_RX_CMD: rxCmdR <= regWdata[1:0];
          A_RX_CLR: rxClrR <= regWdata[0];
          A_LADDR:  laR    <= regWdata[LA_W:0];
          default: ;
        endcase
      end
      if (strobe.rxWrFirst) begin
        rxBuf[0] <= rxByte;
        rxFill   <= FILL_W'(1);
      end else if (strobe.rxWrMore) begin
        rxBuf[rxFill[IDX_W-1:0]] <= rxByte;
        rxFill <= rxFill + FILL_W'(1);
      end
      if (txClrR) begin
        for (int i = 0; i < BUF_BYTES; i++) txBuf[i] <= '0;
        txLenR <= '0;
      end
      if (rxClrR) begin
        for (int i = 0; i < BUF_BYTES; i++) rxBuf[i] <= '0;
        rxFill <= '0;
      end
    end
  end

  always_comb begin
    rxLen = (rxFill == '0) ? '0 : DATA_W'(rxFill - FILL_W'(1));
    st.txCmdWr  = regWe && (regAddr == A_TX_CMD);
    st.txCmdVal = regWdata[1:0];
    st.rxCmdWr  = regWe && (regAddr == A_RX_CMD);
    st.rxCmdVal = regWdata[1:0];
    st.rxClr    = rxClrR;
    st.laEn     = laR[LA_W];
    st.laVal    = laR[LA_W-1:0];
    st.rxFull   = rxFill[IDX_W];
    txLen       = txLenR;
    txRdByte    = txBuf[txRdIdx];
    regRdata    = '0;
    if (regAddr[7:4] == PAGE_TX)      regRdata = txBuf[regAddr[IDX_W-1:0]];
    else if (regAddr[7:4] == PAGE_RX) regRdata = rxBuf[regAddr[IDX_W-1:0]];
    case (regAddr)
      A_TX_LEN:  regRdata = DATA_W'(txLenR);
      A_TX_CMD:  regRdata = DATA_W'(txCmdR);
      A_TX_CLR:  regRdata = DATA_W'(txClrR);
      A_RX_CMD:  regRdata = DATA_W'(rxCmdR);
      A_RX_CLR:  regRdata = DATA_W'(rxClrR);
      A_LADDR:   regRdata = DATA_W'(laR);
      A_RX_LEN:  regRdata = rxLen;
      A_RX_STAT: regRdata = DATA_W'(rxStat);
      A_RX_CNT:  regRdata = DATA_W'(rxCnt);
      A_TX_STAT: regRdata = DATA_W'(txStat);
      default: ;
    endcase
  end
endmodule

// File: rtl/msg_buf_ctl.sv
module msg_buf_ctl
  import msg_buf_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  dp_state_t       st,
  input  logic            rxValid,
  input  logic [LA_W-1:0] hdrNib,
  input  logic            rxFirst,
  input  logic            rxEnd,
  input  logic            rxErr,
  input  logic            txDone,
  input  logic            txErr,
  output dp_strobe_t      strobe,
  output stat_e           txStat,
  output stat_e           rxStat,
  output logic            rxCnt,
  output logic            txStart,
  output logic            txAbort,
  output logic            txIrq,
  output logic            rxIrq
);
  logic rxOff, rxOvf, accept, inFrame, more, ovfNow, filterOk;

  always_comb begin
    filterOk = (hdrNib == st.laVal) || (hdrNib == {LA_W{1'b1}});
    accept   = rxValid && rxFirst && st.laEn && !rxOff && !rxCnt &&
               (rxStat != ST_BUSY) && filterOk && !st.rxClr;
    inFrame  = accept || (rxStat == ST_BUSY);
    more     = inFrame && rxValid && !rxFirst;
    ovfNow   = more && st.rxFull;
    strobe.rxWrFirst = accept;
    strobe.rxWrMore  = more && !st.rxFull;
  end

  // transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txStat <= ST_IDLE; txStart <= 1'b0; txAbort <= 1'b0; txIrq <= 1'b0;
    end else begin
      txStart <= 1'b0;
      txAbort <= 1'b0;
      if (txStat == ST_BUSY && txDone) begin
        txStat <= txErr ? ST_ERR : ST_OK;
        txIrq  <= 1'b1;
      end
      if (st.txCmdWr) begin
        txIrq <= 1'b0;
        case (st.txCmdVal)
          CMD_CUR, CMD_NEXT:
            if (txStat != ST_BUSY) begin txStat <= ST_BUSY; txStart <= 1'b1; end
          CMD_STOP:
            if (txStat == ST_BUSY) begin txStat <= ST_IDLE; txAbort <= 1'b1; end
          default:
            if (txStat != ST_BUSY) txStat <= ST_IDLE;
        endcase
      end
    end
  end

  // receive side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxStat <= ST_IDLE; rxCnt <= 1'b0; rxIrq <= 1'b0; rxOff <= 1'b0; rxOvf <= 1'b0;
    end else begin
      if (accept) begin
        rxStat <= ST_BUSY;
        rxOvf  <= 1'b0;
      end
      if (ovfNow) rxOvf <= 1'b1;
      if (inFrame && rxValid && rxEnd) begin
        rxStat <= (rxErr || ovfNow || (rxOvf && !accept)) ? ST_ERR : ST_OK;
        rxCnt  <= 1'b1;
        rxIrq  <= 1'b1;
      end
      if (st.rxCmdWr) begin
        case (st.rxCmdVal)
          CMD_STOP: rxOff <= 1'b1;
          CMD_NOP:  rxOff <= 1'b0;
          default: begin
            rxOff <= 1'b0; rxCnt <= 1'b0; rxStat <= ST_IDLE; rxIrq <= 1'b0;
          end
        endcase
      end
      if (st.rxClr) begin
        rxCnt <= 1'b0; rxStat <= ST_IDLE; rxIrq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msg_buf_ctrl.sv
module msg_buf_ctrl
  import msg_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              txStart,
  output logic              txAbort,
  output logic [IDX_W-1:0]  txLen,
  input  logic [IDX_W-1:0]  txRdIdx,
  output logic [DATA_W-1:0] txRdByte,
  input  logic              txDone,
  input  logic              txErr,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxFirst,
  input  logic              rxEnd,
  input  logic              rxErr,
  output logic              txIrq,
  output logic              rxIrq
);
  dp_strobe_t strobe;
  dp_state_t  st;
  stat_e      txStat, rxStat;
  logic       rxCnt;

  msg_buf_dp i_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxByte(rxByte),
    .strobe(strobe), .txRdIdx(txRdIdx), .txRdByte(txRdByte), .txLen(txLen),
    .txStat(txStat), .rxStat(rxStat), .rxCnt(rxCnt), .st(st)
  );

  msg_buf_ctl i_ctl (
    .clk(clk), .rstN(rstN), .st(st), .rxValid(rxValid),
    .hdrNib(rxByte[LA_W-1:0]), .rxFirst(rxFirst), .rxEnd(rxEnd),
    .rxErr(rxErr), .txDone(txDone), .txErr(txErr), .strobe(strobe),
    .txStat(txStat), .rxStat(rxStat), .rxCnt(rxCnt), .txStart(txStart),
    .txAbort(txAbort), .txIrq(txIrq), .rxIrq(rxIrq)
  );
endmodule

// File: rtl/msg_buf_chk.sv
module msg_buf_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txStart,
  input logic       txAbort,
  input logic       txIrq,
  input logic       rxIrq,
  input logic [1:0] txStat,
  input logic [1:0] rxStat,
  input logic       rxCnt,
  input logic       laEn,
  input logic       rxClr
);
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> txStat == 2'd1);

  assert_irq_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (txStat == 2'd2 || txStat == 2'd3));

  assert_abort_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |-> (txStat == 2'd0 && !txIrq));

  assert_rx_irq_cnt_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxCnt);

  assert_rx_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxStat == 2'd1 && $past(rxStat) != 2'd1) |-> ($past(laEn) && !$past(rxCnt)));

  assert_rx_clear_R13: assert property (@(posedge clk) disable iff (!rstN)
    rxClr |=> (!rxCnt && rxStat == 2'd0 && !rxIrq));
endmodule

bind msg_buf_ctrl msg_buf_chk i_chk (
  .clk(clk), .rstN(rstN), .txStart(txStart), .txAbort(txAbort),
  .txIrq(txIrq), .rxIrq(rxIrq), .txStat(txStat), .rxStat(rxStat),
  .rxCnt(rxCnt), .laEn(st.laEn), .rxClr(st.rxClr)
);

// File: tb/test_msg_buf_ctrl.sv
module test_msg_buf_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regAddr = '0, regWdata = '0, regRdata;
  logic       txStart, txAbort, txIrq, rxIrq;
  logic [3:0] txLen, txRdIdx = '0;
  logic [7:0] txRdByte;
  logic       txDone = 1'b0, txErr = 1'b0;
  logic       rxValid = 1'b0, rxFirst = 1'b0, rxEnd = 1'b0, rxErr = 1'b0;
  logic [7:0] rxByte = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  msg_buf_ctrl i_msg_buf_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .txStart(txStart),
    .txAbort(txAbort), .txLen(txLen), .txRdIdx(txRdIdx), .txRdByte(txRdByte),
    .txDone(txDone), .txErr(txErr), .rxValid(rxValid), .rxByte(rxByte),
    .rxFirst(rxFirst), .rxEnd(rxEnd), .rxErr(rxErr), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic chkRd(input string req, input logic [7:0] a, input int exp);
    regAddr = a; #1;
    chk(req, int'(regRdata), exp);
  endtask

  task automatic rxFrame(input logic [7:0] hdr, input int n, input bit err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxFirst = (i == 0); rxEnd = (i == n - 1);
      rxByte = (i == 0) ? hdr : 8'(8'h30 + i);
      rxErr = err && (i == n - 1);
    end
    @(negedge clk); rxValid = 1'b0; rxFirst = 1'b0; rxEnd = 1'b0; rxErr = 1'b0;
  endtask

  task automatic pulseDone(input bit e);
    @(negedge clk); txDone = 1'b1; txErr = e;
    @(negedge clk); txDone = 1'b0; txErr = 1'b0;
  endtask

  task automatic tResetState;
    chkRd("R1", 8'h93, 0); chkRd("R1", 8'h91, 0); chkRd("R1", 8'h92, 0);
    chk("R1", {txIrq, rxIrq, txStart, txAbort}, 0);
  endtask

  task automatic tTxLoad;
    wr(8'h00, 8'h40); wr(8'h01, 8'h04); wr(8'h02, 8'h11); wr(8'h10, 8'h02);
    chkRd("R2", 8'h01, 8'h04); chkRd("R2", 8'h10, 2);
    txRdIdx = 4'd2; #1;
    chk("R2", int'(txRdByte), 8'h11); chk("R2", int'(txLen), 2);
  endtask

  task automatic tTxSend(input bit e);
    @(negedge clk); regWe = 1'b1; regAddr = 8'h11; regWdata = 8'h01;
    @(negedge clk); regWe = 1'b0;
    chk("R3", int'(txStart), 1); chkRd("R3", 8'h93, 1);
    @(negedge clk); chk("R3", int'(txStart), 0);
    pulseDone(e);
    chkRd("R4", 8'h93, e ? 3 : 2); chk("R4", int'(txIrq), 1);
    wr(8'h11, 8'h00);
    chkRd("R6", 8'h93, 0); chk("R6", int'(txIrq), 0);
  endtask

  task automatic tTxAbort;
    wr(8'h11, 8'h03); chkRd("R3", 8'h93, 1);
    @(negedge clk); regWe = 1'b1; regAddr = 8'h11; regWdata = 8'h02;
    @(negedge clk); regWe = 1'b0;
    chk("R5", int'(txAbort), 1); chkRd("R5", 8'h93, 0); chk("R5", int'(txIrq), 0);
    wr(8'h11, 8'h00);
  endtask

  task automatic tTxClear;
    wr(8'h13, 8'h01); wr(8'h13, 8'h00);
    chkRd("R7", 8'h00, 0); chkRd("R7", 8'h02, 0); chkRd("R7", 8'h10, 0);
  endtask

  task automatic tRxNoEnable;
    wr(8'h16, 8'h04);
    rxFrame(8'h04, 3, 0);
    chkRd("R8", 8'h91, 0); chkRd("R8", 8'h92, 0); chk("R8", int'(rxIrq), 0);
  endtask

  task automatic tRxAccept;
    wr(8'h16, 8'h14);
    rxFrame(8'h04, 3, 0);
    chkRd("R9", 8'h91, 2); chkRd("R9", 8'h92, 1); chk("R9", int'(rxIrq), 1);
    chkRd("R9", 8'h80, 8'h04); chkRd("R9", 8'h82, 8'h32); chkRd("R9", 8'h90, 2);
  endtask

  task automatic tRxLockAck;
    rxFrame(8'h0F, 2, 0);
    chkRd("R11", 8'h80, 8'h04); chkRd("R11", 8'h90, 2);
    wr(8'h14, 8'h01);
    chkRd("R11", 8'h92, 0); chkRd("R11", 8'h91, 0); chk("R11", int'(rxIrq), 0);
  endtask

  task automatic tRxBroadcast;
    rxFrame(8'h4F, 1, 0);
    chkRd("R8", 8'h91, 2); chkRd("R8", 8'h80, 8'h4F); chkRd("R9", 8'h90, 0);
    wr(8'h14, 8'h03);
    chkRd("R11", 8'h92, 0);
  endtask

  task automatic tRxMismatch;
    rxFrame(8'h05, 2, 0);
    chkRd("R8", 8'h91, 0); chkRd("R8", 8'h92, 0); chkRd("R8", 8'h80, 8'h4F);
  endtask

  task automatic tRxErrors;
    rxFrame(8'h04, 2, 1);
    chkRd("R10", 8'h91, 3); chk("R10", int'(rxIrq), 1);
    wr(8'h14, 8'h01);
    rxFrame(8'h04, 17, 0);
    chkRd("R10", 8'h91, 3); chkRd("R10", 8'h90, 15); chkRd("R10", 8'h8F, 8'h3F);
    wr(8'h14, 8'h01);
  endtask

  task automatic tRxDisable;
    wr(8'h14, 8'h02);
    rxFrame(8'h04, 2, 0);
    chkRd("R12", 8'h91, 0); chkRd("R12", 8'h92, 0); chk("R12", int'(rxIrq), 0);
    wr(8'h14, 8'h00);
    rxFrame(8'h04, 2, 0);
    chkRd("R12", 8'h91, 2); chkRd("R12", 8'h92, 1);
  endtask

  task automatic tRxClear;
    wr(8'h15, 8'h01); wr(8'h15, 8'h00);
    chkRd("R13", 8'h92, 0); chkRd("R13", 8'h91, 0); chkRd("R13", 8'h80, 0);
    chk("R13", int'(rxIrq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tTxLoad();
    tTxSend(1'b0);
    tTxSend(1'b1);
    tTxAbort();
    tTxClear();
    tRxNoEnable();
    tRxAccept();
    tRxLockAck();
    tRxBroadcast();
    tRxMismatch();
    tRxErrors();
    tRxDisable();
    tRxClear();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule